// File: doc/BRIEF.md
# Cascadable Serial Shift-and-Latch Receiver

This block is a serial receiver for a synchronous four-wire bus. It has a shift register of parameterised width and a parallel output register that holds its value. Several copies can be wired in series: each copy's serial output drives the next copy's serial input, and all copies share the serial clock. Each copy has its own active-low select. While a copy's select is low, it takes in one bit on every sampling edge of the serial clock, most significant bit first. At the same time its serial output presents the oldest bit still held, for the next copy to take. A chain of N copies therefore behaves as one shift register of N times the width. The first word the controller sends ends up in the copy farthest down the chain. The last word stays in the copy nearest the controller.

The output register changes only when select goes back high. At that moment it takes the shift register contents, so every selected copy updates its parallel output at the same instant. Copies whose select stayed high ignore the serial clock and data, and keep both registers as they were. A frame of any bit count is accepted: whatever the shift register holds when select rises is latched, with no error flag.

The block runs from a fast system clock and oversamples the serial clock, select and data through a synchroniser. A mode parameter picks the serial clock idle level and the sampling edge, as the four usual bus modes do. In modes 0 and 3 data is sampled on the rising edge and the serial output changes on the falling edge. In modes 1 and 2 these edges are swapped.

Top module: `spi_chain_latch`

## Requirements
- R1: While select is low, each sampling edge of the serial clock (rising edge in mode 0) shifts the shift register left by one bit and puts the serial input into bit 0. A single selected device clocked with 8 bits holds them most significant bit first.
- R2: The serial output shows shift register bit WIDTH-1. It is reloaded on the opposite clock edge and while select is high, so it is stable at every sampling edge and, between frames, equals the top bit of the shift register.
- R3: Three devices on a shared select that receive a 24-bit frame hold its first byte in the farthest device, its middle byte in the middle device and its last byte in the nearest device.
- R4: When select rises, the output register takes the shift register contents. At no other time does the output register change.
- R5: A device whose select stays high keeps its output register and its shift register unchanged, whatever the serial clock and data do.
- R6: In one frame, any non-empty subset of devices can be selected. Every selected device updates its output at the end of that frame, and the others keep theirs.
- R7: A frame whose bit count is not a multiple of the width latches the partially shifted contents as they stand: old low bits move up, and the new bits fill from bit 0.
- R8: Synchronous active-low reset clears the output register, the shift register and the serial output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the bus controller |
| cs_n | input | 1 | Active-low device select; its rising edge commits data |
| din | input | 1 | Serial data in, from the controller or the previous device |
| dout | output | 1 | Serial data out, to the next device in the chain |
| q | output | WIDTH | Parallel output holding register |

## Verification
The bench builds three copies with WIDTH of 8, mode 0 and two synchroniser stages, wired in series with separate selects. This setup makes the 24-bit whole-chain frame, the landing position of each byte and partial-chain frames reachable. It also covers frames where an upstream device is deselected, so that a selected downstream device shifts in the upstream device's frozen top bit. Random frames with random bit counts from 1 to 30 and random selection masks exercise short frames, long frames and frames that cross byte boundaries. Directed frames pin down the byte ordering, a two-device subset and a 5-bit partial frame.

// File: rtl/spi_chain_pkg.sv
// Package: shared event type and mode decoding for the cascadable
// shift-and-latch receiver. Assumes the usual four bus modes 0..3, where
// bit 1 is the serial clock idle level and bit 0 is the phase.
package spi_chain_pkg;

    // Per-cycle strobes derived from the synchronised bus lines.
    typedef struct packed {
        logic sample;   // sampling edge of the serial clock while selected
        logic launch;   // output-change edge of the serial clock while selected
        logic close_f;  // select has just returned high
    } chain_evt_t;

    // True when data is sampled on the rising serial clock edge.
    function automatic logic samples_on_rise(input int unsigned mode);
        return (mode == 0) || (mode == 3);
    endfunction

    // Idle level of the serial clock for a mode.
    function automatic logic idle_level(input int unsigned mode);
        return mode >= 2;
    endfunction

endpackage

// File: rtl/chain_sync.sv
// Module: multi-stage synchroniser for a small bundle of asynchronous
// bus lines. All bits travel through the same number of stages, so they
// keep their relative timing. Assumes STAGES >= 1.
module chain_sync #(
    parameter int              STAGES  = 2,
    parameter int              BITS    = 3,
    parameter logic [BITS-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] async_i,
    output logic [BITS-1:0] sync_o
);

    logic [BITS-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw bus lines.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= async_i;
            end
        end else begin : g_next
            // Later stages: pass the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign sync_o = pipe[STAGES-1];

endmodule

// File: rtl/chain_edge_det.sv
// Module: turns the synchronised serial clock and select into one-cycle
// strobes. MODE chooses which serial clock edge samples and which edge
// launches. Serial clock edges count only while select is low. Assumes
// the serial clock is slow against clk, with several clk cycles per phase.
module chain_edge_det
    import spi_chain_pkg::*;
#(
    parameter int unsigned MODE = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_s,
    input  logic       cs_n_s,
    output chain_evt_t evt
);

    localparam logic SAMPLE_RISE = samples_on_rise(MODE);
    localparam logic SCLK_IDLE   = idle_level(MODE);

    logic sclk_d;
    logic cs_n_d;
    logic rise;
    logic fall;
    logic selected;

    // Remember last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= SCLK_IDLE;
            cs_n_d <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_n_d <= cs_n_s;
        end
    end

    // Derive the strobes from the level changes.
    always_comb begin
        rise        = sclk_s & ~sclk_d;
        fall        = ~sclk_s & sclk_d;
        selected    = ~cs_n_s;
        evt.sample  = selected & (SAMPLE_RISE ? rise : fall);
        evt.launch  = selected & (SAMPLE_RISE ? fall : rise);
        evt.close_f = cs_n_s & ~cs_n_d;
    end

endmodule

// File: rtl/chain_shift_core.sv
// Module: the shift register, the serial output stage and the parallel
// holding register. It acts only on the strobes from the edge detector.
// The serial output is a staging copy of the top shift bit, so a chain
// of devices adds no extra bit per device.
module chain_shift_core
    import spi_chain_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chain_evt_t       evt,
    input  logic             cs_n_s,
    input  logic             din_s,
    output logic [WIDTH-1:0] sr,
    output logic             dout,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] sr_next;

    if (WIDTH == 1) begin : g_one
        // Single-bit register: the new bit replaces the old one.
        always_comb sr_next = din_s;
    end else begin : g_wide
        // Shift left, new bit into bit 0.
        always_comb sr_next = {sr[WIDTH-2:0], din_s};
    end

    // Shift on each sampling strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          sr <= '0;
        else if (evt.sample) sr <= sr_next;
    end

    // Reload the serial output on the launch edge and while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)                    dout <= 1'b0;
        else if (cs_n_s || evt.launch) dout <= sr[WIDTH-1];
    end

    // Commit the shift register when select returns high.
    always_ff @(posedge clk) begin
        if (!rst_n)           q <= '0;
        else if (evt.close_f) q <= sr;
    end

endmodule

// File: rtl/spi_chain_latch.sv
// Top: cascadable serial shift-and-latch receiver. It oversamples sclk,
// cs_n and din on clk, turns the serial clock and select into strobes,
// and drives the shift and hold registers from them. Assumes each serial
// clock phase lasts at least SYNC_STAGES + 4 clk cycles.
module spi_chain_latch
    import spi_chain_pkg::*;
#(
    parameter int          WIDTH       = 8,
    parameter int unsigned MODE        = 0,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             din,
    output logic             dout,
    output logic [WIDTH-1:0] q
);

    localparam logic       SCLK_IDLE = idle_level(MODE);
    localparam logic [2:0] LINE_RST  = {SCLK_IDLE, 1'b1, 1'b0};

    logic [2:0]       lines_s;
    logic             sclk_s;
    logic             cs_n_s;
    logic             din_s;
    chain_evt_t       evt_w;
    logic [WIDTH-1:0] sr_w;

    chain_sync #(
        .STAGES (SYNC_STAGES),
        .BITS   (3),
        .RST_VAL(LINE_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({sclk, cs_n, din}),
        .sync_o (lines_s)
    );

    assign {sclk_s, cs_n_s, din_s} = lines_s;

    chain_edge_det #(
        .MODE(MODE)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_s(sclk_s),
        .cs_n_s(cs_n_s),
        .evt   (evt_w)
    );

    chain_shift_core #(
        .WIDTH(WIDTH)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_w),
        .cs_n_s(cs_n_s),
        .din_s (din_s),
        .sr    (sr_w),
        .dout  (dout),
        .q     (q)
    );

endmodule

// File: rtl/spi_chain_latch_chk.sv
// Checker: temporal properties of the shift-and-latch receiver, bound to
// every instance of the top module.
module spi_chain_latch_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_s,
    input logic             din_s,
    input logic             sample_stb,
    input logic             close_stb,
    input logic [WIDTH-1:0] sr,
    input logic             dout,
    input logic [WIDTH-1:0] q
);

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> sr == (($past(sr) << 1) | WIDTH'($past(din_s))));

    // R2
    dout_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> dout == sr[WIDTH-1]);

    // R4
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_stb |=> q == $past(sr));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !close_stb |=> $stable(q));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(sr));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q == '0 && sr == '0 && dout == 1'b0));

endmodule

bind spi_chain_latch spi_chain_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .din_s     (din_s),
    .sample_stb(evt_w.sample),
    .close_stb (evt_w.close_f),
    .sr        (sr_w),
    .dout      (dout),
    .q         (q)
);

// File: tb/spi_chain_latch_test.sv
// Bench: three receivers in series, driven by a behavioural bus controller.
module spi_chain_latch_test;

    localparam int W    = 8;
    localparam int NDEV = 3;
    localparam int HALF = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sclk = 1'b0;
    logic [NDEV-1:0]   cs_n = '1;
    logic              mosi = 1'b0;
    logic [NDEV-1:0]   din_v;
    logic [NDEV-1:0]   dout_v;
    logic [NDEV*W-1:0] q_flat;

    int errors = 0;
    int checks = 0;

    logic [W-1:0] m_sr [NDEV];
    logic [W-1:0] m_q  [NDEV];

    always #4 clk = ~clk;

    assign din_v = {dout_v[NDEV-2:0], mosi};

    for (genvar i = 0; i < NDEV; i++) begin : g_dev
        spi_chain_latch #(.WIDTH(W), .MODE(0), .SYNC_STAGES(2)) uut (
            .clk  (clk),
            .rst_n(rst_n),
            .sclk (sclk),
            .cs_n (cs_n[i]),
            .din  (din_v[i]),
            .dout (dout_v[i]),
            .q    (q_flat[i*W +: W])
        );
    end

    function automatic logic [W-1:0] q_of(input int i);
        return q_flat[i*W +: W];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half_period();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic model_clear();
        for (int i = 0; i < NDEV; i++) begin
            m_sr[i] = '0;
            m_q[i]  = '0;
        end
    endtask

    // One frame: select devices, clock nbits MSB-first, release select.
    task automatic run_frame(input logic [NDEV-1:0] sel, input int nbits, input logic [31:0] data);
        logic b;
        cs_n = ~sel;
        half_period();
        for (int k = 0; k < nbits; k++) begin
            b = data[nbits-1-k];
            mosi = b;
            for (int i = NDEV-1; i >= 0; i--) begin
                if (sel[i]) m_sr[i] = {m_sr[i][W-2:0], (i == 0) ? b : m_sr[i-1][W-1]};
            end
            half_period();
            sclk = 1'b1;
            half_period();
            sclk = 1'b0;
        end
        half_period();
        cs_n = '1;
        for (int i = 0; i < NDEV; i++) if (sel[i]) m_q[i] = m_sr[i];
        repeat (12) @(negedge clk);
    endtask

    // Compare every device against the model after a frame.
    task automatic check_all(input logic [NDEV-1:0] sel);
        for (int i = 0; i < NDEV; i++) begin
            if (sel[i]) check("R4 selected device latches at select rise", q_of(i), m_q[i]);
            else        check("R5 deselected device keeps its output", q_of(i), m_q[i]);
        end
        check("R2 chain end output shows top shift bit", dout_v[NDEV-1], m_sr[NDEV-1][W-1]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [NDEV-1:0] sel;
        int              nb;
        logic [31:0]     dat;
        void'($urandom(32'd20240611));
        model_clear();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R8: reset state
        for (int i = 0; i < NDEV; i++) check("R8 output cleared by reset", q_of(i), 8'h00);
        check("R8 serial output cleared by reset", dout_v, 3'b000);

        // R1: single device, one byte MSB-first
        run_frame(3'b001, 8, 32'hA5);
        check("R1 single device byte MSB first", q_of(0), 8'hA5);
        check_all(3'b001);

        // R3: whole chain, 24-bit frame
        run_frame(3'b111, 24, 32'hA1B2C3);
        check("R3 first byte in farthest device", q_of(2), 8'hA1);
        check("R3 middle byte in middle device", q_of(1), 8'hB2);
        check("R3 last byte in nearest device", q_of(0), 8'hC3);
        check("R2 chain end output between frames", dout_v[2], 1'b1);
        check_all(3'b111);

        // R6: subset of two devices, farthest one untouched
        run_frame(3'b011, 16, 32'h5A3C);
        check("R6 subset middle device updated", q_of(1), 8'h5A);
        check("R6 subset nearest device updated", q_of(0), 8'h3C);
        check("R6 subset farthest device unchanged", q_of(2), 8'hA1);
        check_all(3'b011);

        // R7: partial 5-bit frame latched as it stands
        run_frame(3'b001, 5, 32'h16);
        check("R7 partial frame latched as shifted", q_of(0), 8'h96);
        check_all(3'b001);

        // R5: clock while no device is selected
        run_frame(3'b000, 9, 32'h1FF);
        check_all(3'b000);

        // Random frames with random masks and bit counts (R4, R5, R6, R7)
        for (int n = 0; n < 40; n++) begin
            sel = NDEV'($urandom_range(1, 7));
            nb  = $urandom_range(1, 30);
            dat = $urandom;
            run_frame(sel, nb, dat);
            check_all(sel);
        end

        // R8: reset after activity clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        repeat (4) @(negedge clk);
        for (int i = 0; i < NDEV; i++) check("R8 output cleared by later reset", q_of(i), 8'h00);
        check("R8 serial output cleared by later reset", dout_v, 3'b000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule